// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is the host side of a byte-wide parallel printer port. Software reaches it through a small register bus with an address, separate read and write strobes and 8-bit write and read data. Three consecutive byte addresses, starting at a base address, select the three registers. The output latch holds one byte and drives the eight data pins. The read-only status register shows the printer's handshake lines. The control register drives the four printer control lines and holds an interrupt enable.

Software sends a character in four steps. It polls the status register until the ready bit is 1. It writes the byte to the output latch. It sets the strobe bit in the control register and then clears it again. The block does not time the strobe pulse. The printer inputs pass through a two-flop synchronizer before software can see them. When interrupts are enabled, a falling edge on the acknowledge line raises an interrupt request, and the next read of the status register clears it.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset, the data pins are 0x00, all four control outputs are low and `irq_o` is low. The data register reads back 0x00 and the control register reads back 0x00.
- R2: A write to BASE+0 latches `bus_wdata`. The byte appears on `pd_o` on the clock edge that takes the write, and it stays there until the next write to BASE+0. A read of BASE+0 returns the latched byte.
- R3: A read of BASE+1 returns the following bits. Bit 7 is the inverse of the synchronized busy input, so 1 means ready. Bit 6 is acknowledge, bit 5 is paper-out, bit 4 is online and bit 3 is fault. Bits 2:0 read as 0.
- R4: A write to BASE+1 changes neither the data pins nor the control register.
- R5: In the control register, bit 0 drives `stb_o`, bit 1 drives `afd_o`, bit 2 drives `ini_o`, bit 3 drives `sel_in_o`, and bit 4 is the interrupt enable, which drives no pin. Bits 7:5 are not stored and read as 0.
- R6: A read at any address outside BASE+0 to BASE+2 returns 0x00, and a write there has no effect.
- R7: While the interrupt enable is 1, a 1-to-0 transition of the synchronized acknowledge input sets `irq_o`. While the enable is 0, the same transition leaves `irq_o` low.
- R8: A read of BASE+1 clears `irq_o` on the clock edge that takes the read. `irq_o` falls at no other time.
- R9: A change on a printer input is visible in the status register exactly two clock edges after the input changes, and not after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| pd_o | output | 8 | Printer data pins |
| stb_o | output | 1 | Strobe output |
| afd_o | output | 1 | Auto line feed output |
| ini_o | output | 1 | Initialize output |
| sel_in_o | output | 1 | Select-in output |
| prn_busy_i | input | 1 | Printer busy input |
| prn_ack_i | input | 1 | Printer acknowledge input |
| prn_paper_i | input | 1 | Paper-out input |
| prn_online_i | input | 1 | Printer online input |
| prn_fault_i | input | 1 | Printer fault input |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check five things on every cycle:
- A data write shows up on the data pins, and the strobe follows control bit 0.
- Status writes leave all state alone, and out-of-range reads return zero.
- The unused control bits read as zero.
- The ready bit equals the inverse of the busy input from two cycles earlier.
- `irq_o` rises only while the enable is set, and falls only after a status read.

Only the bench's scenarios can show the rest:
- The reset values.
- The full status bit layout across many input patterns.
- That a disabled enable suppresses an acknowledge edge.
- That the status bit has not yet changed one edge after an input changes.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Control register bit positions
  localparam int CB_STB = 0;
  localparam int CB_AFD = 1;
  localparam int CB_INI = 2;
  localparam int CB_SEL = 3;
  localparam int CB_IEN = 4;
  localparam logic [7:0] CTRL_MASK = 8'h1F;

  // Index of each input inside the synchronized vector
  localparam int IN_FAULT  = 0;
  localparam int IN_ONLINE = 1;
  localparam int IN_PAPER  = 2;
  localparam int IN_ACK    = 3;
  localparam int IN_BUSY   = 4;
  localparam int IN_W      = 5;

endpackage

// File: rtl/lpt_rst_sync.sv
module lpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d_i;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lpt_decode.sv
module lpt_decode
  import lpt_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0378
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] A_DATA = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR + ADDR_W'(2);

  always_comb begin
    if      (addr_i == A_DATA) sel_o = SEL_DATA;
    else if (addr_i == A_STAT) sel_o = SEL_STAT;
    else if (addr_i == A_CTRL) sel_o = SEL_CTRL;
    else                       sel_o = SEL_NONE;
  end
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  reg_sel_e        sel_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [7:0]      wdata_i,
  input  logic [IN_W-1:0] pins_s_i,
  output logic [7:0]      rdata_o,
  output logic [7:0]      data_q_o,
  output logic [7:0]      ctrl_q_o,
  output logic            stat_rd_o
);
  logic [7:0] data_q, data_d;
  logic [7:0] ctrl_q, ctrl_d;
  logic       data_en, ctrl_en;
  logic [7:0] stat_val;

  always_comb begin
    data_en = wr_i && (sel_i == SEL_DATA);
    ctrl_en = wr_i && (sel_i == SEL_CTRL);
    data_d  = wdata_i;
    ctrl_d  = wdata_i & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      ctrl_q <= 8'h00;
    end else begin
      if (data_en) data_q <= data_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    stat_val = {~pins_s_i[IN_BUSY], pins_s_i[IN_ACK], pins_s_i[IN_PAPER],
                pins_s_i[IN_ONLINE], pins_s_i[IN_FAULT], 3'b000};
    rdata_o = 8'h00;
    if (rd_i) begin
      unique case (sel_i)
        SEL_DATA: rdata_o = data_q;
        SEL_STAT: rdata_o = stat_val;
        SEL_CTRL: rdata_o = ctrl_q;
        default:  rdata_o = 8'h00;
      endcase
    end
    stat_rd_o = rd_i && (sel_i == SEL_STAT);
  end

  assign data_q_o = data_q;
  assign ctrl_q_o = ctrl_q;
endmodule

// File: rtl/lpt_irq.sv
module lpt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s_i,
  input  logic ien_i,
  input  logic stat_rd_i,
  output logic irq_o
);
  logic ack_d_q, pend_q, pend_d, ack_fall;

  always_comb begin
    ack_fall = ack_d_q && !ack_s_i;
    // A new edge wins over a clearing read in the same cycle
    pend_d   = (ack_fall && ien_i) || (pend_q && !stat_rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      ack_d_q <= ack_s_i;
      pend_q  <= pend_d;
    end
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
  import lpt_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0378,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        pd_o,
  output logic              stb_o,
  output logic              afd_o,
  output logic              ini_o,
  output logic              sel_in_o,
  input  logic              prn_busy_i,
  input  logic              prn_ack_i,
  input  logic              prn_paper_i,
  input  logic              prn_online_i,
  input  logic              prn_fault_i,
  output logic              irq_o
);
  logic            rst_core_n;
  logic [IN_W-1:0] pins_raw, pins_s;
  reg_sel_e        sel;
  logic [7:0]      ctrl_q;
  logic            stat_rd;

  lpt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_o(rst_core_n)
  );

  always_comb begin
    pins_raw            = '0;
    pins_raw[IN_BUSY]   = prn_busy_i;
    pins_raw[IN_ACK]    = prn_ack_i;
    pins_raw[IN_PAPER]  = prn_paper_i;
    pins_raw[IN_ONLINE] = prn_online_i;
    pins_raw[IN_FAULT]  = prn_fault_i;
  end

  lpt_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d_i(pins_raw), .q_o(pins_s)
  );

  lpt_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i(bus_addr), .sel_o(sel)
  );

  lpt_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .sel_i(sel), .wr_i(bus_wr), .rd_i(bus_rd),
    .wdata_i(bus_wdata), .pins_s_i(pins_s), .rdata_o(bus_rdata),
    .data_q_o(pd_o), .ctrl_q_o(ctrl_q), .stat_rd_o(stat_rd)
  );

  lpt_irq u_irq (
    .clk(clk), .rst_n(rst_core_n), .ack_s_i(pins_s[IN_ACK]),
    .ien_i(ctrl_q[CB_IEN]), .stat_rd_i(stat_rd), .irq_o(irq_o)
  );

  assign stb_o    = ctrl_q[CB_STB];
  assign afd_o    = ctrl_q[CB_AFD];
  assign ini_o    = ctrl_q[CB_INI];
  assign sel_in_o = ctrl_q[CB_SEL];
endmodule

// File: rtl/lpt_port_ctrl_chk.sv
module lpt_port_ctrl_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0378
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pd_o,
  input logic              stb_o,
  input logic              prn_busy_i,
  input logic [7:0]        ctrl_q,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_DATA = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE_ADDR + ADDR_W'(2);

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  logic out_of_range;
  assign out_of_range = (bus_addr != A_DATA) && (bus_addr != A_STAT) && (bus_addr != A_CTRL);

  p_data_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA) |=> (pd_o == $past(bus_wdata)));

  p_stat_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT) |=> ($stable(pd_o) && $stable(ctrl_q)));

  p_ctrl_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_CTRL) |-> (bus_rdata[7:5] == 3'b000));

  p_strobe_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=> (stb_o == $past(bus_wdata[0])));

  p_outside_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && out_of_range) |-> (bus_rdata == 8'h00));

  p_ready_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT && warm_q == 2'd2) |-> (bus_rdata[7] == !$past(prn_busy_i, 2)));

  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ctrl_q[4]));

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(bus_rd && bus_addr == A_STAT));
endmodule

bind lpt_port_ctrl lpt_port_ctrl_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_o(pd_o),
  .stb_o(stb_o), .prn_busy_i(prn_busy_i), .ctrl_q(ctrl_q), .irq_o(irq_o)
);

// File: tb/lpt_port_ctrl_tb.sv
module lpt_port_ctrl_tb_top;
  localparam int          ADDR_W = 16;
  localparam logic [15:0] BASE   = 16'h0378;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata, pd_o;
  logic        stb_o, afd_o, ini_o, sel_in_o, irq_o;
  logic        busy, ack, paper, online, fault;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lpt_port_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_o(pd_o), .stb_o(stb_o),
    .afd_o(afd_o), .ini_o(ini_o), .sel_in_o(sel_in_o), .prn_busy_i(busy),
    .prn_ack_i(ack), .prn_paper_i(paper), .prn_online_i(online),
    .prn_fault_i(fault), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_status(logic b, logic a, logic p, logic o, logic f);
    return {~b, a, p, o, f, 3'b000};
  endfunction

  function automatic logic [7:0] exp_ctrl_pins(logic [7:0] c);
    return {4'h0, c[3], c[2], c[1], c[0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_pins(logic [4:0] v);
    @(negedge clk);
    {busy, ack, paper, online, fault} = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl_pins_now();
    return {4'h0, sel_in_o, ini_o, afd_o, stb_o};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd, exp_data, exp_ctrl;
    logic [4:0] pins;
    int unsigned seed;
    seed = $urandom(32'h1A2B3C4D);
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    {busy, ack, paper, online, fault} = 5'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pd_o", pd_o, 8'h00);
    chk("R1 ctrl pins", ctrl_pins_now(), 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    bus_read(BASE, rd);        chk("R1 data rd", rd, 8'h00);
    bus_read(BASE + 16'd2, rd); chk("R1 ctrl rd", rd, 8'h00);
    bus_read(BASE + 16'd1, rd); chk("R3 reset status", rd, 8'h80);

    // R2 data path
    bus_write(BASE, 8'hA5);
    chk("R2 pins", pd_o, 8'hA5);
    bus_read(BASE, rd); chk("R2 readback", rd, 8'hA5);

    // R5 control layout and masking
    bus_write(BASE + 16'd2, 8'hFF);
    chk("R5 pins all", ctrl_pins_now(), 8'h0F);
    bus_read(BASE + 16'd2, rd); chk("R5 readback masked", rd, 8'h1F);
    bus_write(BASE + 16'd2, 8'h05);
    chk("R5 pins stb ini", ctrl_pins_now(), 8'h05);
    bus_write(BASE + 16'd2, 8'h00);

    // R4 write to status ignored
    bus_write(BASE + 16'd1, 8'h5A);
    chk("R4 data kept", pd_o, 8'hA5);
    bus_read(BASE + 16'd2, rd); chk("R4 ctrl kept", rd, 8'h00);

    // R6 outside the register window
    bus_write(BASE + 16'd3, 8'h77);
    bus_write(BASE - 16'd1, 8'h1F);
    chk("R6 data kept", pd_o, 8'hA5);
    chk("R6 ctrl kept", ctrl_pins_now(), 8'h00);
    bus_read(BASE + 16'd3, rd); chk("R6 read above", rd, 8'h00);
    bus_read(BASE - 16'd1, rd); chk("R6 read below", rd, 8'h00);

    // R9 two-edge input latency, read strobe held
    @(negedge clk);
    busy = 1'b1; bus_addr = BASE + 16'd1; bus_rd = 1'b1;
    @(negedge clk); #1 chk("R9 after one edge", {7'b0, bus_rdata[7]}, 8'h01);
    @(negedge clk); #1 chk("R9 after two edges", {7'b0, bus_rdata[7]}, 8'h00);
    bus_rd = 1'b0;

    // R3 directed pattern
    set_pins(5'b11010);
    bus_read(BASE + 16'd1, rd); chk("R3 pattern", rd, exp_status(1, 1, 0, 1, 0));
    set_pins(5'b00101);
    bus_read(BASE + 16'd1, rd); chk("R3 pattern2", rd, exp_status(0, 0, 1, 0, 1));

    // R7 / R8 interrupt
    bus_write(BASE + 16'd2, 8'h10);
    set_pins(5'b01000);
    bus_read(BASE + 16'd1, rd);
    chk("R7 idle", {7'b0, irq_o}, 8'h00);
    set_pins(5'b00000);
    repeat (2) @(negedge clk);
    chk("R7 set on ack fall", {7'b0, irq_o}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R8 held until read", {7'b0, irq_o}, 8'h01);
    bus_read(BASE + 16'd1, rd);
    chk("R8 cleared by status read", {7'b0, irq_o}, 8'h00);
    bus_write(BASE + 16'd2, 8'h00);
    set_pins(5'b01000);
    set_pins(5'b00000);
    repeat (3) @(negedge clk);
    chk("R7 disabled no irq", {7'b0, irq_o}, 8'h00);

    // Random mix
    exp_data = 8'hA5; exp_ctrl = 8'h00; pins = 5'b00000;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      case ($urandom % 6)
        0: begin bus_write(BASE, v); exp_data = v;
                 chk("R2 rnd pins", pd_o, exp_data); end
        1: begin bus_write(BASE + 16'd2, v); exp_ctrl = v & 8'h1F;
                 chk("R5 rnd pins", ctrl_pins_now(), exp_ctrl_pins(exp_ctrl)); end
        2: begin bus_write(BASE + 16'd1, v);
                 chk("R4 rnd data", pd_o, exp_data);
                 chk("R4 rnd ctrl", ctrl_pins_now(), exp_ctrl_pins(exp_ctrl)); end
        3: begin pins = 5'($urandom); set_pins(pins);
                 bus_read(BASE + 16'd1, rd);
                 chk("R3 rnd status", rd, exp_status(pins[4], pins[3], pins[2], pins[1], pins[0])); end
        4: begin bus_read(BASE, rd); chk("R2 rnd read", rd, exp_data);
                 bus_read(BASE + 16'd2, rd); chk("R5 rnd read", rd, exp_ctrl); end
        default: begin
                 bus_write(BASE + 16'd3 + 16'(v), v);
                 bus_read(BASE + 16'd3 + 16'(v), rd);
                 chk("R6 rnd read", rd, 8'h00);
                 chk("R6 rnd data", pd_o, exp_data); end
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule